// File: doc/BRIEF.md
# Exception Entry Register Update

This block holds the processor state registers that change when an exception or interrupt is taken: status, cause, the exception return address, the faulting address, shadow register set control and interrupt mask levels. When the pipeline takes an event it raises a one-cycle take strobe together with the event's class, code, program counters and side information. All affected fields are then updated in a single clock edge.

Reset and non-maskable events raise the error level. Every other event raises the exception level. The return address and the branch-delay indication are captured only when the block was not already at exception level, so a nested fault keeps the outer return point. A maskable interrupt pushes the current interrupt mask into a previous-mask field and loads the detected level. Unless shadow switching is disabled, it also saves the current register set number and selects the set that matches the level.

Software reads the fields from the output ports and writes them through a simple select/data write port. When the take strobe and a software write fall in the same cycle, the take strobe wins.

Top module: `exc_entry_regs`

## Requirements
- R1: After the asynchronous reset, EXL=0, ERL=1, BEV=1 and the NMI flag is 0. CSS, PSS, CMASK, PMASK, the shadow-disable bit, the cause fields, EPC and the bad address are all 0.
- R2: The event class is encoded as 0=reset, 1=non-maskable, 2=maskable interrupt, 3=other exception. A take of class 0 or 1 sets ERL. Class 0 also clears the NMI flag and sets BEV. Class 1 sets the NMI flag. Classes 2 and 3 set EXL.
- R3: `int_block_o` is 1 whenever EXL or ERL is 1, and 0 when both are 0.
- R4: On a take with EXL=0 before the edge, the branch-delay bit takes `delay_slot_i`. EPC takes `branch_pc_i` when that input is 1 and `pc_i` when it is 0. With EXL=1 before the edge, both keep their values.
- R5: Every take loads the exception code field from `code_i`.
- R6: Only a take with code 11 (coprocessor unusable) loads the CE field from `cop_i`. Any other take leaves CE unchanged.
- R7: Only a take with code 4 or 5 (address error on load or store) loads the bad address from `fault_addr_i`. Any other take leaves it unchanged.
- R8: A take of class 2 loads CMASK from `level_i` and PMASK from the old CMASK. Other classes leave both unchanged.
- R9: A take of class 2 with the shadow-disable bit at 0 copies CSS into PSS. It then loads CSS with min(level, NUM_SETS-1). With the shadow-disable bit at 1, CSS and PSS keep their values.
- R10: A software write updates one register, chosen by `sw_sel_i` (the layouts are bit positions within `sw_wdata_i`):
  - 0 = status: EXL bit 0, ERL bit 1, NMI bit 2, BEV bit 3.
  - 1 = cause: code at bits 0 upward, CE at bits 9:8, branch-delay at bit 31.
  - 2 = EPC.
  - 3 = bad address.
  - 4 = shadow: CSS at bits 0 upward, PSS at bits 8 upward, shadow-disable at bit 16.
  - 5 = level: CMASK at bits 0 upward, PMASK at bits 8 upward.
- R11: In a cycle with both a take and a software write, the software write is dropped and only the take's updates occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| take_i | input | 1 | One-cycle strobe: an event is taken |
| cls_i | input | 2 | Event class (0 reset, 1 non-maskable, 2 maskable, 3 exception) |
| code_i | input | CODE_W | Exception code |
| delay_slot_i | input | 1 | Faulting instruction sits in a branch delay slot |
| pc_i | input | ADDR_W | PC of the faulting instruction |
| branch_pc_i | input | ADDR_W | PC of the preceding branch |
| fault_addr_i | input | ADDR_W | Offending virtual address |
| cop_i | input | 2 | Referenced coprocessor number |
| level_i | input | LVL_W | Detected interrupt level |
| sw_we_i | input | 1 | Software write enable |
| sw_sel_i | input | 3 | Software write register select |
| sw_wdata_i | input | 32 | Software write data |
| exl_o | output | 1 | Exception level bit |
| erl_o | output | 1 | Error level bit |
| nmi_o | output | 1 | Non-maskable event flag |
| bev_o | output | 1 | Boot vector bit |
| int_block_o | output | 1 | Interrupts blocked |
| cause_bd_o | output | 1 | Branch-delay bit |
| cause_ce_o | output | 2 | Coprocessor number field |
| cause_code_o | output | CODE_W | Exception code field |
| epc_o | output | ADDR_W | Exception return address |
| badaddr_o | output | ADDR_W | Bad virtual address |
| css_o | output | SET_W | Current shadow set |
| pss_o | output | SET_W | Previous shadow set |
| ssd_o | output | 1 | Shadow switching disabled |
| cmask_o | output | LVL_W | Current interrupt mask level |
| pmask_o | output | LVL_W | Previous interrupt mask level |

## Verification
The takes are exercised in several forms:
- A fresh fault outside a delay slot and one inside a slot tell apart which PC reaches EPC.
- A nested fault taken at exception level separates the conditional return-point capture from the unconditional code capture.
- Codes 4, 11 and an unrelated code show that the bad address and CE move only for their own codes.

Two interrupts at different levels, one above the number of sets, check the mask stacking and the clamped set choice. A third interrupt, taken with shadow switching disabled, shows that the sets are held. Reset-class and non-maskable takes split the ERL, NMI-flag and BEV effects. Takes coinciding with software writes to EPC and to the bad address show that the take has priority.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  typedef enum logic [1:0] {
    CLS_RESET = 2'd0,
    CLS_NMI   = 2'd1,
    CLS_INT   = 2'd2,
    CLS_EXC   = 2'd3
  } exc_cls_e;

  typedef enum logic [2:0] {
    SEL_STATUS  = 3'd0,
    SEL_CAUSE   = 3'd1,
    SEL_EPC     = 3'd2,
    SEL_BADADDR = 3'd3,
    SEL_SHADOW  = 3'd4,
    SEL_LEVEL   = 3'd5
  } reg_sel_e;

  localparam int CODE_ADDR_LD   = 4;
  localparam int CODE_ADDR_ST   = 5;
  localparam int CODE_COP_UNUSE = 11;

  // software write field positions
  localparam int ST_EXL      = 0;
  localparam int ST_ERL      = 1;
  localparam int ST_NMI      = 2;
  localparam int ST_BEV      = 3;
  localparam int CA_CE_LSB   = 8;
  localparam int CA_BD       = 31;
  localparam int SH_PSS_LSB  = 8;
  localparam int SH_SSD      = 16;
  localparam int LV_PMSK_LSB = 8;

endpackage

// File: rtl/exc_set_map.sv
module exc_set_map #(
  parameter int LVL_W    = 3,
  parameter int NUM_SETS = 4,
  parameter int SET_W    = 2
) (
  input  logic [LVL_W-1:0] level_i,
  output logic [SET_W-1:0] set_o
);

  generate
    if ((1 << LVL_W) <= NUM_SETS) begin : g_direct
      // every level has its own set
      assign set_o = SET_W'(level_i);
    end else begin : g_clamp
      localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(NUM_SETS - 1);
      assign set_o = (level_i >= TOP_LVL) ? SET_W'(NUM_SETS - 1)
                                          : SET_W'(level_i);
    end
  endgenerate

endmodule

// File: rtl/exc_capture_dec.sv
module exc_capture_dec
  import exc_entry_pkg::*;
#(
  parameter int CODE_W = 5
) (
  input  logic              take_i,
  input  logic [1:0]        cls_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              exl_q_i,
  input  logic              ssd_q_i,
  output logic              wr_ctx_o,
  output logic              wr_ce_o,
  output logic              wr_bad_o,
  output logic              wr_mask_o,
  output logic              wr_shadow_o
);

  logic is_int;

  always_comb begin
    is_int      = (exc_cls_e'(cls_i) == CLS_INT);
    wr_ctx_o    = take_i && !exl_q_i;
    wr_ce_o     = take_i && (code_i == CODE_W'(CODE_COP_UNUSE));
    wr_bad_o    = take_i && ((code_i == CODE_W'(CODE_ADDR_LD)) ||
                             (code_i == CODE_W'(CODE_ADDR_ST)));
    wr_mask_o   = take_i && is_int;
    wr_shadow_o = take_i && is_int && !ssd_q_i;
  end

endmodule

// File: rtl/exc_entry_regs.sv
module exc_entry_regs
  import exc_entry_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int CODE_W   = 5,
  parameter int LVL_W    = 3,
  parameter int NUM_SETS = 4,
  parameter int SET_W    = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic [1:0]        cls_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              delay_slot_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [ADDR_W-1:0] branch_pc_i,
  input  logic [ADDR_W-1:0] fault_addr_i,
  input  logic [1:0]        cop_i,
  input  logic [LVL_W-1:0]  level_i,
  input  logic              sw_we_i,
  input  logic [2:0]        sw_sel_i,
  input  logic [31:0]       sw_wdata_i,
  output logic              exl_o,
  output logic              erl_o,
  output logic              nmi_o,
  output logic              bev_o,
  output logic              int_block_o,
  output logic              cause_bd_o,
  output logic [1:0]        cause_ce_o,
  output logic [CODE_W-1:0] cause_code_o,
  output logic [ADDR_W-1:0] epc_o,
  output logic [ADDR_W-1:0] badaddr_o,
  output logic [SET_W-1:0]  css_o,
  output logic [SET_W-1:0]  pss_o,
  output logic              ssd_o,
  output logic [LVL_W-1:0]  cmask_o,
  output logic [LVL_W-1:0]  pmask_o
);

  // state
  logic              exl_q, erl_q, nmi_q, bev_q, bd_q, ssd_q;
  logic [1:0]        ce_q;
  logic [CODE_W-1:0] code_q;
  logic [ADDR_W-1:0] epc_q, bad_q;
  logic [SET_W-1:0]  css_q, pss_q;
  logic [LVL_W-1:0]  cmask_q, pmask_q;

  // next state
  logic              exl_d, erl_d, nmi_d, bev_d, bd_d, ssd_d;
  logic [1:0]        ce_d;
  logic [CODE_W-1:0] code_d;
  logic [ADDR_W-1:0] epc_d, bad_d;
  logic [SET_W-1:0]  css_d, pss_d;
  logic [LVL_W-1:0]  cmask_d, pmask_d;

  logic              wr_ctx, wr_ce, wr_bad, wr_mask, wr_shadow;
  logic [SET_W-1:0]  lvl_set;
  logic [31:0]       unused_wdata;

  assign unused_wdata = sw_wdata_i;

  exc_capture_dec #(.CODE_W(CODE_W)) u_dec (
    .take_i      (take_i),
    .cls_i       (cls_i),
    .code_i      (code_i),
    .exl_q_i     (exl_q),
    .ssd_q_i     (ssd_q),
    .wr_ctx_o    (wr_ctx),
    .wr_ce_o     (wr_ce),
    .wr_bad_o    (wr_bad),
    .wr_mask_o   (wr_mask),
    .wr_shadow_o (wr_shadow)
  );

  exc_set_map #(.LVL_W(LVL_W), .NUM_SETS(NUM_SETS), .SET_W(SET_W)) u_map (
    .level_i (level_i),
    .set_o   (lvl_set)
  );

  always_comb begin
    exl_d = exl_q;  erl_d = erl_q;  nmi_d = nmi_q;  bev_d = bev_q;
    bd_d  = bd_q;   ce_d  = ce_q;   code_d = code_q;
    epc_d = epc_q;  bad_d = bad_q;
    css_d = css_q;  pss_d = pss_q;  ssd_d = ssd_q;
    cmask_d = cmask_q;  pmask_d = pmask_q;

    if (take_i) begin
      unique case (exc_cls_e'(cls_i))
        CLS_RESET: begin erl_d = 1'b1; nmi_d = 1'b0; bev_d = 1'b1; end
        CLS_NMI:   begin erl_d = 1'b1; nmi_d = 1'b1; end
        default:   exl_d = 1'b1;
      endcase
      code_d = code_i;
      if (wr_ctx) begin
        bd_d  = delay_slot_i;
        epc_d = delay_slot_i ? branch_pc_i : pc_i;
      end
      if (wr_ce)  ce_d  = cop_i;
      if (wr_bad) bad_d = fault_addr_i;
      if (wr_mask) begin
        cmask_d = level_i;
        pmask_d = cmask_q;
      end
      if (wr_shadow) begin
        pss_d = css_q;
        css_d = lvl_set;
      end
    end else if (sw_we_i) begin
      case (reg_sel_e'(sw_sel_i))
        SEL_STATUS: begin
          exl_d = sw_wdata_i[ST_EXL];
          erl_d = sw_wdata_i[ST_ERL];
          nmi_d = sw_wdata_i[ST_NMI];
          bev_d = sw_wdata_i[ST_BEV];
        end
        SEL_CAUSE: begin
          code_d = sw_wdata_i[CODE_W-1:0];
          ce_d   = sw_wdata_i[CA_CE_LSB +: 2];
          bd_d   = sw_wdata_i[CA_BD];
        end
        SEL_EPC:     epc_d = sw_wdata_i[ADDR_W-1:0];
        SEL_BADADDR: bad_d = sw_wdata_i[ADDR_W-1:0];
        SEL_SHADOW: begin
          css_d = sw_wdata_i[SET_W-1:0];
          pss_d = sw_wdata_i[SH_PSS_LSB +: SET_W];
          ssd_d = sw_wdata_i[SH_SSD];
        end
        SEL_LEVEL: begin
          cmask_d = sw_wdata_i[LVL_W-1:0];
          pmask_d = sw_wdata_i[LV_PMSK_LSB +: LVL_W];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exl_q <= 1'b0;  erl_q <= 1'b1;  nmi_q <= 1'b0;  bev_q <= 1'b1;
      bd_q  <= 1'b0;  ce_q  <= '0;    code_q <= '0;
      epc_q <= '0;    bad_q <= '0;
      css_q <= '0;    pss_q <= '0;    ssd_q <= 1'b0;
      cmask_q <= '0;  pmask_q <= '0;
    end else begin
      exl_q <= exl_d;  erl_q <= erl_d;  nmi_q <= nmi_d;  bev_q <= bev_d;
      bd_q  <= bd_d;   ce_q  <= ce_d;   code_q <= code_d;
      epc_q <= epc_d;  bad_q <= bad_d;
      css_q <= css_d;  pss_q <= pss_d;  ssd_q <= ssd_d;
      cmask_q <= cmask_d;  pmask_q <= pmask_d;
    end
  end

  assign exl_o        = exl_q;
  assign erl_o        = erl_q;
  assign nmi_o        = nmi_q;
  assign bev_o        = bev_q;
  assign int_block_o  = exl_q | erl_q;
  assign cause_bd_o   = bd_q;
  assign cause_ce_o   = ce_q;
  assign cause_code_o = code_q;
  assign epc_o        = epc_q;
  assign badaddr_o    = bad_q;
  assign css_o        = css_q;
  assign pss_o        = pss_q;
  assign ssd_o        = ssd_q;
  assign cmask_o      = cmask_q;
  assign pmask_o      = pmask_q;

endmodule

// File: rtl/exc_entry_regs_chk.sv
module exc_entry_regs_chk
  import exc_entry_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CODE_W = 5,
  parameter int LVL_W  = 3,
  parameter int SET_W  = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              take_i,
  input logic [1:0]        cls_i,
  input logic [CODE_W-1:0] code_i,
  input logic [LVL_W-1:0]  level_i,
  input logic              sw_we_i,
  input logic [2:0]        sw_sel_i,
  input logic              exl_o,
  input logic              erl_o,
  input logic              nmi_o,
  input logic              int_block_o,
  input logic              cause_bd_o,
  input logic [1:0]        cause_ce_o,
  input logic [ADDR_W-1:0] epc_o,
  input logic [ADDR_W-1:0] badaddr_o,
  input logic [SET_W-1:0]  css_o,
  input logic [SET_W-1:0]  pss_o,
  input logic              ssd_o,
  input logic [LVL_W-1:0]  cmask_o,
  input logic [LVL_W-1:0]  pmask_o
);

  p_err_level_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i && !cls_i[1] |=> erl_o);

  p_exc_level_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i && cls_i[1] |=> exl_o);

  p_nmi_flag_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i && (cls_i == 2'd1) |=> nmi_o);

  p_block_after_take_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |=> int_block_o);

  p_ctx_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i && exl_o |=> $stable(epc_o) && $stable(cause_bd_o));

  p_ce_keep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i && (code_i != CODE_W'(CODE_COP_UNUSE)) |=> $stable(cause_ce_o));

  p_mask_stack_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i && (cls_i == 2'd2) |=> (cmask_o == $past(level_i)) && (pmask_o == $past(cmask_o)));

  p_shadow_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i && ssd_o |=> $stable(css_o) && $stable(pss_o));

  p_take_wins_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i && sw_we_i && (sw_sel_i == 3'd3) &&
    (code_i != CODE_W'(CODE_ADDR_LD)) && (code_i != CODE_W'(CODE_ADDR_ST))
    |=> $stable(badaddr_o));

endmodule

bind exc_entry_regs exc_entry_regs_chk #(
  .ADDR_W(ADDR_W), .CODE_W(CODE_W), .LVL_W(LVL_W), .SET_W(SET_W)
) u_chk (.*);

// File: tb/tb_exc_entry_regs.sv
module tb_exc_entry_regs;

  localparam int ADDR_W = 32, CODE_W = 5, LVL_W = 3, NUM_SETS = 4, SET_W = 2;

  logic              clk = 1'b0, rst_n = 1'b0;
  logic              take = 1'b0, delay = 1'b0, sw_we = 1'b0;
  logic [1:0]        cls = '0, cop = '0;
  logic [CODE_W-1:0] code = '0;
  logic [ADDR_W-1:0] pc = '0, bpc = '0, faddr = '0;
  logic [LVL_W-1:0]  level = '0;
  logic [2:0]        sw_sel = '0;
  logic [31:0]       sw_wdata = '0;

  logic              exl, erl, nmi, bev, blk, bd, ssd;
  logic [1:0]        ce;
  logic [CODE_W-1:0] ccode;
  logic [ADDR_W-1:0] epc, bad;
  logic [SET_W-1:0]  css, pss;
  logic [LVL_W-1:0]  cmask, pmask;

  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  exc_entry_regs #(.ADDR_W(ADDR_W), .CODE_W(CODE_W), .LVL_W(LVL_W),
                   .NUM_SETS(NUM_SETS)) dut (
    .clk_i(clk), .rst_ni(rst_n), .take_i(take), .cls_i(cls), .code_i(code),
    .delay_slot_i(delay), .pc_i(pc), .branch_pc_i(bpc), .fault_addr_i(faddr),
    .cop_i(cop), .level_i(level), .sw_we_i(sw_we), .sw_sel_i(sw_sel),
    .sw_wdata_i(sw_wdata), .exl_o(exl), .erl_o(erl), .nmi_o(nmi), .bev_o(bev),
    .int_block_o(blk), .cause_bd_o(bd), .cause_ce_o(ce), .cause_code_o(ccode),
    .epc_o(epc), .badaddr_o(bad), .css_o(css), .pss_o(pss), .ssd_o(ssd),
    .cmask_o(cmask), .pmask_o(pmask)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one-cycle take; outputs are read on the following falling edge
  task automatic do_take(input logic [1:0] c, input logic [CODE_W-1:0] cd,
                         input logic ds, input logic [ADDR_W-1:0] p,
                         input logic [ADDR_W-1:0] bp, input logic [ADDR_W-1:0] fa,
                         input logic [1:0] cp, input logic [LVL_W-1:0] lv);
    @(negedge clk);
    take = 1'b1; cls = c; code = cd; delay = ds; pc = p; bpc = bp;
    faddr = fa; cop = cp; level = lv;
    @(negedge clk);
    take = 1'b0;
  endtask

  task automatic sw_write(input logic [2:0] sel, input logic [31:0] data);
    @(negedge clk);
    sw_we = 1'b1; sw_sel = sel; sw_wdata = data;
    @(negedge clk);
    sw_we = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1", "exl", 32'(exl), 0);   chk("R1", "erl", 32'(erl), 1);
    chk("R1", "bev", 32'(bev), 1);   chk("R1", "nmi", 32'(nmi), 0);
    chk("R1", "css", 32'(css), 0);   chk("R1", "pss", 32'(pss), 0);
    chk("R1", "cmask", 32'(cmask), 0); chk("R1", "pmask", 32'(pmask), 0);
    chk("R1", "epc", epc, 0);        chk("R3", "block at reset", 32'(blk), 1);
  endtask

  task automatic t_sw_status;
    sw_write(3'd0, 32'h8);
    chk("R10", "erl cleared", 32'(erl), 0);
    chk("R10", "bev kept", 32'(bev), 1);
    chk("R3", "unblocked", 32'(blk), 0);
  endtask

  task automatic t_addr_err;
    do_take(2'd3, 5'd4, 1'b0, 32'h1000, 32'hFFC, 32'hDEAD0001, 2'd0, 3'd0);
    chk("R2", "exl set", 32'(exl), 1);
    chk("R3", "blocked", 32'(blk), 1);
    chk("R4", "epc = pc", epc, 32'h1000);
    chk("R4", "bd clear", 32'(bd), 0);
    chk("R5", "code", 32'(ccode), 4);
    chk("R7", "badaddr", bad, 32'hDEAD0001);
  endtask

  task automatic t_nested;
    do_take(2'd3, 5'd11, 1'b1, 32'h2000, 32'h1FFC, 32'h55, 2'd2, 3'd0);
    chk("R4", "epc held", epc, 32'h1000);
    chk("R4", "bd held", 32'(bd), 0);
    chk("R6", "ce loaded", 32'(ce), 2);
    chk("R7", "badaddr held", bad, 32'hDEAD0001);
    chk("R5", "code", 32'(ccode), 11);
  endtask

  task automatic t_delay_slot;
    sw_write(3'd0, 32'h8);
    do_take(2'd3, 5'd8, 1'b1, 32'h3004, 32'h3000, 32'h77, 2'd1, 3'd0);
    chk("R4", "epc = branch pc", epc, 32'h3000);
    chk("R4", "bd set", 32'(bd), 1);
    chk("R6", "ce held", 32'(ce), 2);
  endtask

  task automatic t_int_shadow;
    sw_write(3'd0, 32'h8);
    sw_write(3'd5, 32'h2);
    chk("R10", "cmask write", 32'(cmask), 2);
    do_take(2'd2, 5'd0, 1'b0, 32'h500, 32'h4FC, 32'h0, 2'd0, 3'd5);
    chk("R8", "cmask = level", 32'(cmask), 5);
    chk("R8", "pmask = old", 32'(pmask), 2);
    chk("R9", "css clamped", 32'(css), 3);
    chk("R9", "pss = old css", 32'(pss), 0);
    chk("R2", "exl on int", 32'(exl), 1);
    sw_write(3'd0, 32'h8);
    do_take(2'd2, 5'd0, 1'b0, 32'h600, 32'h5FC, 32'h0, 2'd0, 3'd2);
    chk("R9", "css = level", 32'(css), 2);
    chk("R9", "pss = prior css", 32'(pss), 3);
    chk("R8", "pmask stacks", 32'(pmask), 5);
  endtask

  task automatic t_int_ssd;
    sw_write(3'd4, 32'h0001_0001);
    chk("R10", "ssd write", 32'(ssd), 1);
    sw_write(3'd0, 32'h8);
    do_take(2'd2, 5'd0, 1'b0, 32'h700, 32'h6FC, 32'h0, 2'd0, 3'd1);
    chk("R9", "css held", 32'(css), 1);
    chk("R9", "pss held", 32'(pss), 0);
    chk("R8", "cmask", 32'(cmask), 1);
    chk("R8", "pmask", 32'(pmask), 2);
  endtask

  task automatic t_nmi_and_reset_cls;
    do_take(2'd1, 5'd0, 1'b0, 32'h800, 32'h7FC, 32'h0, 2'd0, 3'd6);
    chk("R2", "nmi flag", 32'(nmi), 1);
    chk("R2", "erl on nmi", 32'(erl), 1);
    chk("R8", "cmask kept on nmi", 32'(cmask), 1);
    sw_write(3'd0, 32'h4);
    chk("R10", "bev cleared", 32'(bev), 0);
    do_take(2'd0, 5'd0, 1'b0, 32'h900, 32'h8FC, 32'h0, 2'd0, 3'd0);
    chk("R2", "nmi cleared", 32'(nmi), 0);
    chk("R2", "erl on reset", 32'(erl), 1);
    chk("R2", "bev on reset", 32'(bev), 1);
  endtask

  task automatic t_priority;
    sw_write(3'd0, 32'h8);
    @(negedge clk);
    take = 1'b1; cls = 2'd3; code = 5'd9; delay = 1'b0; pc = 32'h4000;
    sw_we = 1'b1; sw_sel = 3'd2; sw_wdata = 32'h1234_5678;
    @(negedge clk);
    take = 1'b0; sw_we = 1'b0;
    chk("R11", "epc from take", epc, 32'h4000);
    @(negedge clk);
    take = 1'b1; cls = 2'd3; code = 5'd9;
    sw_we = 1'b1; sw_sel = 3'd3; sw_wdata = 32'h0BAD_0BAD;
    @(negedge clk);
    take = 1'b0; sw_we = 1'b0;
    chk("R11", "badaddr kept", bad, 32'hDEAD0001);
    sw_write(3'd2, 32'h0000_ABCD);
    chk("R10", "epc write", epc, 32'h0000_ABCD);
    sw_write(3'd1, 32'h8000_0103);
    chk("R10", "cause bd", 32'(bd), 1);
    chk("R10", "cause ce", 32'(ce), 1);
    chk("R10", "cause code", 32'(ccode), 3);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sw_status();
    t_addr_err();
    t_nested();
    t_delay_slot();
    t_int_shadow();
    t_int_ssd();
    t_nmi_and_reset_cls();
    t_priority();
    finish_run();
  end

endmodule